// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block is the control engine behind a flash mode that programs two bytes per command and keeps the target address itself. An SPI front end gives it the chip-select level and a strobe for each received byte. The block splits each chip-select frame into an opcode and its payload. When chip select is released, it decides whether the frame starts the mode, continues it, ends it or has no effect. For each accepted word it raises a one-cycle program request that carries an even word address and two data bytes. The array side reports completion on `prog_done`.

The first word command carries a full address. Every later one carries only data, and the block advances its internal word address by two after each request. While the mode is active, the block accepts only a small set of commands. It leaves the mode when the host disables writes, or by itself once the word that ends at the highest unprotected address has finished. Protection is given as two inputs: a flag saying everything is protected, and the highest unprotected byte address. A ready/busy level can be driven on the serial output while chip select is low.

Top module: `aai_word_seq`

## Requirements
- R1: After synchronous reset, `aai_mode`, `wel`, `busy`, `prog_req` and `so_oe` are all 0, and serial-output busy signalling is off.
- R2: A one-byte frame with opcode 06h, received while the mode is inactive, sets `wel` when chip select rises.
- R3: A frame of exactly six bytes (ADh, three address bytes most significant first, then data bytes D0 and D1) starts the mode. It must arrive while the mode is inactive, `wel` is 1 and `busy` is 0. It then gives, in the cycle after chip select rises, a one-cycle `prog_req` with `prog_addr` equal to the address with bit 0 cleared and `prog_data` = {D0, D1}. D0 belongs to the even byte and D1 to the odd byte. `aai_mode` and `busy` become 1.
- R4: While the mode is active, a frame of exactly three bytes (ADh, D0, D1) with `busy` at 0 issues a request at the previous word address plus 2.
- R5: A word frame that ends while `busy` is 1 is ignored and the word address does not advance. A `prog_done` pulse clears `busy`.
- R6: A word frame is ignored when `all_prot` is 1, when the word's odd byte address (bit 0 set) is above `unprot_top`, or, for a starting frame, when `wel` is 0.
- R7: A word whose odd byte address equals `unprot_top` is the last one. When its `prog_done` arrives, `aai_mode` and `wel` are cleared.
- R8: A one-byte frame with opcode 04h clears `aai_mode` and `wel` at any time, and cancels a pending top-of-range exit.
- R9: While the mode is active, every other frame has no effect. This covers opcodes 06h, 70h and 80h, and word frames of the wrong length.
- R10: Outside the mode, a one-byte frame 70h turns serial-output busy signalling on and 80h turns it off. When it is on and either the mode is active or `busy` is 1, `so_oe` is 1 while `cs_n` is low and `so_out` = NOT `busy`. Otherwise `so_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, low during a frame |
| byte_valid | input | 1 | One received byte is on `byte_in` |
| byte_in | input | 8 | Received byte |
| unprot_top | input | ADDR_W | Highest unprotected byte address |
| all_prot | input | 1 | Whole array protected |
| prog_done | input | 1 | Array finished the current word |
| prog_req | output | 1 | One-cycle word program request |
| prog_addr | output | ADDR_W | Even byte address of the word |
| prog_data | output | 16 | {even byte, odd byte} |
| aai_mode | output | 1 | Mode status bit |
| wel | output | 1 | Write-enable latch |
| busy | output | 1 | A word program is in flight |
| so_oe | output | 1 | Serial output driven |
| so_out | output | 1 | Ready level on serial output (1 = ready) |

## Verification
Directed frames walk one complete session: a start at an odd address, which must come out even, a word sent while busy, a continuation, commands that are not allowed in the mode, disabling writes, and a run that reaches the top address. Together they separate address forcing, stepping and the automatic exit. Random frames then mix random opcodes, random lengths, start addresses within a few words of a randomly chosen top address, and completion pulses at random times. This shows whether length checking, the busy gate and the protection compare hold when they meet in orders nobody wrote by hand. The serial output is sampled inside every frame, which covers enable, disable and the ignored toggles.

// File: rtl/aai_seq_pkg.sv
package aai_seq_pkg;

    localparam logic [7:0] OP_WORD    = 8'hAD;
    localparam logic [7:0] OP_WEN     = 8'h06;
    localparam logic [7:0] OP_WDIS    = 8'h04;
    localparam logic [7:0] OP_SOBSY_1 = 8'h70;
    localparam logic [7:0] OP_SOBSY_0 = 8'h80;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WORD,
        CMD_WEN,
        CMD_WDIS,
        CMD_SO_ON,
        CMD_SO_OFF
    } cmd_kind_t;

    typedef struct packed {
        logic mode;
        logic wel;
        logic busy;
        logic so_en;
        logic exit_pend;
    } seq_flags_t;

    function automatic cmd_kind_t decode_op(input logic [7:0] op);
        case (op)
            OP_WORD:    return CMD_WORD;
            OP_WEN:     return CMD_WEN;
            OP_WDIS:    return CMD_WDIS;
            OP_SOBSY_1: return CMD_SO_ON;
            OP_SOBSY_0: return CMD_SO_OFF;
            default:    return CMD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/aai_frame_rx.sv
module aai_frame_rx #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cs_n,
    input  logic                   byte_valid,
    input  logic [7:0]             byte_in,
    output logic                   frame_end,
    output logic [7:0]             op,
    output logic [CNT_W-1:0]       nbytes,
    output logic [ADDR_W+15:0]     payload
);
    localparam int PAY_W = ADDR_W + 16;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q    <= 1'b1;
            op      <= '0;
            nbytes  <= '0;
            payload <= '0;
        end else begin
            cs_q <= cs_n;
            if (cs_n) begin
                nbytes <= '0;
            end else if (byte_valid) begin
                if (nbytes == '0) op <= byte_in;
                else payload <= {payload[PAY_W-9:0], byte_in};
                if (nbytes != CNT_MAX) nbytes <= nbytes + 1'b1;
            end
        end
    end

    assign frame_end = cs_n & ~cs_q;

    // R3: a released frame starts the next one from an empty count
    a_r3_count_clears: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (nbytes == '0));

endmodule

// File: rtl/aai_seq_ctrl.sv
module aai_seq_ctrl
    import aai_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   frame_end,
    input  logic [7:0]             op,
    input  logic [CNT_W-1:0]       nbytes,
    input  logic [ADDR_W+15:0]     payload,
    input  logic [ADDR_W-1:0]      unprot_top,
    input  logic                   all_prot,
    input  logic                   prog_done,
    output logic                   prog_req,
    output logic [ADDR_W-1:0]      prog_addr,
    output logic [15:0]            prog_data,
    output seq_flags_t             flags
);
    localparam int PAY_W      = ADDR_W + 16;
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int FULL_LEN   = 1 + ADDR_BYTES + 2;
    localparam int SHORT_LEN  = 3;

    cmd_kind_t         kind;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] entry_addr;
    logic [ADDR_W-1:0] cand;
    logic [ADDR_W-1:0] cand_odd;
    logic              len_ok;
    logic              go_word;
    logic              one_byte;

    always_comb begin
        kind       = decode_op(op);
        entry_addr = {payload[PAY_W-1:17], 1'b0};
        cand       = flags.mode ? cur_addr : entry_addr;
        cand_odd   = {cand[ADDR_W-1:1], 1'b1};
        len_ok     = flags.mode ? (nbytes == CNT_W'(SHORT_LEN))
                                : ((nbytes == CNT_W'(FULL_LEN)) && flags.wel);
        go_word    = frame_end && (kind == CMD_WORD) && !flags.busy && len_ok
                     && !all_prot && !(cand_odd > unprot_top);
        one_byte   = frame_end && (nbytes == CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags     <= '0;
            cur_addr  <= '0;
            prog_req  <= 1'b0;
            prog_addr <= '0;
            prog_data <= '0;
        end else begin
            prog_req <= 1'b0;
            if (prog_done) begin
                flags.busy <= 1'b0;
                if (flags.exit_pend) begin
                    flags.mode      <= 1'b0;
                    flags.wel       <= 1'b0;
                    flags.exit_pend <= 1'b0;
                end
            end
            if (go_word) begin
                prog_req        <= 1'b1;
                prog_addr       <= cand;
                prog_data       <= payload[15:0];
                cur_addr        <= cand + ADDR_W'(2);
                flags.mode      <= 1'b1;
                flags.busy      <= 1'b1;
                flags.exit_pend <= (cand_odd == unprot_top);
            end else if (one_byte) begin
                case (kind)
                    CMD_WDIS: begin
                        flags.mode      <= 1'b0;
                        flags.wel       <= 1'b0;
                        flags.exit_pend <= 1'b0;
                    end
                    CMD_WEN:    if (!flags.mode) flags.wel   <= 1'b1;
                    CMD_SO_ON:  if (!flags.mode) flags.so_en <= 1'b1;
                    CMD_SO_OFF: if (!flags.mode) flags.so_en <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    // R3: a request leaves the sequencer in the mode and busy
    a_r3_req_sets_state: assert property (@(posedge clk) disable iff (rst)
        prog_req |-> (flags.mode && flags.busy));

    // R5: nothing is issued while a word is still in flight
    a_r5_no_req_when_busy: assert property (@(posedge clk) disable iff (rst)
        (flags.busy && !prog_done) |=> !prog_req);

    // R4: a continuation word lands on the held address
    a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
        (prog_req && $past(flags.mode)) |-> (prog_addr == $past(cur_addr)));

    // R8: write disable always leaves the mode
    a_r8_wdis_clears: assert property (@(posedge clk) disable iff (rst)
        (one_byte && kind == CMD_WDIS) |=> (!flags.mode && !flags.wel));

    // R2: the mode never runs without the write-enable latch
    a_r2_mode_needs_wel: assert property (@(posedge clk) disable iff (rst)
        flags.mode |-> flags.wel);

endmodule

// File: rtl/aai_so_drv.sv
module aai_so_drv (
    input  logic cs_n,
    input  logic so_en,
    input  logic mode,
    input  logic busy,
    output logic so_oe,
    output logic so_out
);
    always_comb begin
        so_oe  = so_en && (mode || busy) && !cs_n;
        so_out = !busy;
    end
endmodule

// File: rtl/aai_word_seq.sv
module aai_word_seq
    import aai_seq_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              byte_valid,
    input  logic [7:0]        byte_in,
    input  logic [ADDR_W-1:0] unprot_top,
    input  logic              all_prot,
    input  logic              prog_done,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [15:0]       prog_data,
    output logic              aai_mode,
    output logic              wel,
    output logic              busy,
    output logic              so_oe,
    output logic              so_out
);
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int CNT_W      = $clog2(ADDR_BYTES + 4) + 1;

    logic                   frame_end;
    logic [7:0]             op;
    logic [CNT_W-1:0]       nbytes;
    logic [ADDR_W+15:0]     payload;
    seq_flags_t             flags;

    aai_frame_rx #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .frame_end  (frame_end),
        .op         (op),
        .nbytes     (nbytes),
        .payload    (payload)
    );

    aai_seq_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .frame_end  (frame_end),
        .op         (op),
        .nbytes     (nbytes),
        .payload    (payload),
        .unprot_top (unprot_top),
        .all_prot   (all_prot),
        .prog_done  (prog_done),
        .prog_req   (prog_req),
        .prog_addr  (prog_addr),
        .prog_data  (prog_data),
        .flags      (flags)
    );

    aai_so_drv u_so (
        .cs_n   (cs_n),
        .so_en  (flags.so_en),
        .mode   (flags.mode),
        .busy   (flags.busy),
        .so_oe  (so_oe),
        .so_out (so_out)
    );

    assign aai_mode = flags.mode;
    assign wel      = flags.wel;
    assign busy     = flags.busy;

    // R10: the serial output is released whenever chip select is high
    a_r10_so_quiet: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !so_oe);

    // R10: a driven serial output reports busy as 0
    a_r10_so_level: assert property (@(posedge clk) disable iff (rst)
        (so_oe && busy) |-> !so_out);

endmodule

// File: tb/sim_aai_word_seq.sv
module sim_aai_word_seq;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1;
    logic          byte_valid = 1'b0;
    logic [7:0]    byte_in = '0;
    logic [AW-1:0] unprot_top = 24'h1FFFFF;
    logic          all_prot = 1'b0;
    logic          prog_done = 1'b0;
    logic          prog_req;
    logic [AW-1:0] prog_addr;
    logic [15:0]   prog_data;
    logic          aai_mode, wel, busy, so_oe, so_out;

    always #10 clk = ~clk;

    aai_word_seq #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .byte_valid(byte_valid),
        .byte_in(byte_in), .unprot_top(unprot_top), .all_prot(all_prot),
        .prog_done(prog_done), .prog_req(prog_req), .prog_addr(prog_addr),
        .prog_data(prog_data), .aai_mode(aai_mode), .wel(wel), .busy(busy),
        .so_oe(so_oe), .so_out(so_out)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // expected state, kept from the requirements
    logic          m_mode = 0, m_wel = 0, m_busy = 0, m_so = 0, m_pend = 0;
    logic [AW-1:0] m_addr = '0;
    logic          e_req;
    logic [AW-1:0] e_addr;
    logic [15:0]   e_data;
    logic [7:0]    fb [0:5];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic odd_blocked(input logic [AW-1:0] a);
        return all_prot || ({a[AW-1:1], 1'b1} > unprot_top);
    endfunction

    // model of frame release
    task automatic model_frame(input int n);
        logic [AW-1:0] s;
        e_req = 0;
        if (fb[0] == 8'hAD) begin
            if (!m_mode && n == 6 && m_wel && !m_busy) begin
                s = {fb[1], fb[2], fb[3]};
                s[0] = 1'b0;
                e_req = !odd_blocked(s);
            end else if (m_mode && n == 3 && !m_busy) begin
                s = m_addr;
                e_req = !odd_blocked(s);
            end
            if (e_req) begin
                e_addr = s;
                e_data = (n == 6) ? {fb[4], fb[5]} : {fb[1], fb[2]};
                m_mode = 1; m_busy = 1; m_addr = s + 2;
                m_pend = ({s[AW-1:1], 1'b1} == unprot_top);
            end
        end else if (n == 1) begin
            case (fb[0])
                8'h04: begin m_mode = 0; m_wel = 0; m_pend = 0; end
                8'h06: if (!m_mode) m_wel = 1;
                8'h70: if (!m_mode) m_so = 1;
                8'h80: if (!m_mode) m_so = 0;
                default: ;
            endcase
        end
    endtask

    task automatic check_state(input string tag);
        check({tag, " mode"}, aai_mode, m_mode);
        check({tag, " wel"},  wel,      m_wel);
        check({tag, " busy"}, busy,     m_busy);
    endtask

    task automatic send(input int n, input string tag);
        @(negedge clk);
        cs_n = 1'b0;
        #2;
        check("R10 so_oe", so_oe, m_so && (m_mode || m_busy));
        if (so_oe) check("R10 so_out", so_out, !m_busy);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_valid = 1'b1;
            byte_in    = fb[i];
        end
        @(negedge clk);
        byte_valid = 1'b0;
        cs_n = 1'b1;
        model_frame(n);
        @(negedge clk);
        check({tag, " req"}, prog_req, e_req);
        if (e_req) begin
            check({tag, " addr"}, prog_addr, e_addr);
            check({tag, " data"}, prog_data, e_data);
        end
        check_state(tag);
    endtask

    task automatic cmd1(input logic [7:0] op, input string tag);
        fb[0] = op;
        send(1, tag);
    endtask

    task automatic start_word(input logic [AW-1:0] a, input logic [7:0] d0,
                              input logic [7:0] d1, input string tag);
        fb[0] = 8'hAD; fb[1] = a[23:16]; fb[2] = a[15:8]; fb[3] = a[7:0];
        fb[4] = d0; fb[5] = d1;
        send(6, tag);
    endtask

    task automatic next_word(input logic [7:0] d0, input logic [7:0] d1, input string tag);
        fb[0] = 8'hAD; fb[1] = d0; fb[2] = d1;
        send(3, tag);
    endtask

    task automatic done(input string tag);
        @(negedge clk);
        prog_done = 1'b1;
        m_busy = 0;
        if (m_pend) begin m_mode = 0; m_wel = 0; m_pend = 0; end
        @(negedge clk);
        prog_done = 1'b0;
        check_state(tag);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 mode", aai_mode, 0);
        check("R1 wel", wel, 0);
        check("R1 busy", busy, 0);
        check("R1 req", prog_req, 0);
        check("R1 so_oe", so_oe, 0);

        start_word(24'h000101, 8'hA5, 8'h3C, "R6 no wel");
        cmd1(8'h06, "R2 wren");
        cmd1(8'h70, "R10 so on");
        start_word(24'h000101, 8'hA5, 8'h3C, "R3 start");
        next_word(8'h11, 8'h22, "R5 busy word");
        done("R5 done");
        next_word(8'h11, 8'h22, "R4 next");
        cmd1(8'h80, "R9 so off in mode");
        cmd1(8'h06, "R9 wren in mode");
        fb[0] = 8'hAD; fb[1] = 8'h01; fb[2] = 8'h02; fb[3] = 8'h03;
        send(4, "R9 bad length");
        done("R5 done2");
        next_word(8'h33, 8'h44, "R4 next2");
        cmd1(8'h04, "R8 wrdi");
        done("R8 done");

        unprot_top = 24'h00010F;
        cmd1(8'h06, "R2 wren2");
        start_word(24'h00010C, 8'h55, 8'h66, "R3 start2");
        done("R7 done1");
        next_word(8'h77, 8'h88, "R7 last");
        done("R7 exit");
        check("R7 mode cleared", aai_mode, 0);
        check("R7 wel cleared", wel, 0);

        cmd1(8'h06, "R2 wren3");
        start_word(24'h000110, 8'h01, 8'h02, "R6 above top");
        all_prot = 1'b1;
        start_word(24'h000000, 8'h01, 8'h02, "R6 all prot");
        all_prot = 1'b0;

        for (int it = 0; it < 400; it++) begin
            int r;
            if (it % 50 == 0) unprot_top = 24'h000200 + AW'($urandom % 64);
            all_prot = (($urandom % 16) == 0);
            r = $urandom % 10;
            case (r)
                0: cmd1(8'h06, "R2 rnd wren");
                1: if (($urandom % 3) == 0) cmd1(8'h04, "R8 rnd wrdi");
                2: start_word(unprot_top - AW'($urandom % 24) + AW'(($urandom % 8 == 0) ? 4 : 0),
                              8'($urandom), 8'($urandom), "R3 rnd start");
                3, 4: next_word(8'($urandom), 8'($urandom), "R4 rnd next");
                5, 6: done("R5 rnd done");
                7: cmd1(8'h70, "R10 rnd on");
                8: cmd1(8'h80, "R10 rnd off");
                default: begin
                    int n;
                    n = 1 + ($urandom % 6);
                    for (int k = 0; k < 6; k++) fb[k] = 8'($urandom);
                    if (($urandom % 2) == 0) fb[0] = 8'hAD;
                    send(n, "R9 rnd junk");
                end
            endcase
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule